// File: doc/BRIEF.md
# Instruction Fetch Stage with Hold-Until-Accept

This block is the front stage of an in-order pipeline. It keeps a word-addressed program counter, issues one read per counter value to an instruction store whose response latency is not fixed, and captures the returned word into a holding register. The held word is passed on only when the stage is ready and the downstream stage signals that it can take it in the same cycle. The program counter moves forward only at that moment.

While a read is outstanding the stage reports STALLED. Once a word is held it reports OK, and it keeps reporting OK for as long as downstream refuses the word. No new read goes out until the held word has been handed on. Each handoff carries a stamp: the value of a free-running cycle counter in the cycle the transfer took place.

Top module: `instrFetch`

## Requirements
- R1: While reset is low and in the first cycle after it is released, statusOk is 0 (STALLED), outValid is 0 and memAddr is 0. memReq is 1 in that first cycle, so a read of address 0 goes out immediately.
- R2: memReq is never high in two consecutive cycles. It stays low while a read is outstanding.
- R3: From the cycle after a request until the cycle after the matching memValid, statusOk is 0.
- R4: When memValid is high while a read is outstanding, statusOk is 1 in the next cycle and memData from that cycle becomes the held word.
- R5: While a word is held (statusOk is 1), memReq stays low and statusOk stays 1 for as long as nextReady is low.
- R6: A handoff happens only in a cycle where both statusOk and nextReady are 1. In the following cycle outValid is 1 for exactly one cycle, outWord carries the held word, and statusOk is 0.
- R7: memAddr advances by exactly one only on a handoff. It does not change when a word is captured or while a read is outstanding, so each request addresses the word after the one previously handed off.
- R8: A cycle counter reads 0 in the first cycle after reset is released and increments once per cycle. outStamp, valid with outValid, equals the counter value in the handoff cycle.
- R9: A memValid pulse that arrives when no read is outstanding has no effect. The held word and statusOk are unchanged.
- R10: If nextReady is already high in the cycle memValid arrives, the handoff happens one cycle later. It does not happen in the capture cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| memReq | output | 1 | One-cycle read request to instruction storage |
| memAddr | output | ADDR_W | Word address of the request; the current program counter |
| memValid | input | 1 | Read data valid from storage |
| memData | input | DATA_W | Read data from storage |
| nextReady | input | 1 | Downstream stage can accept a word this cycle |
| statusOk | output | 1 | 1 = OK (word held), 0 = STALLED |
| outValid | output | 1 | One-cycle pulse marking a completed handoff |
| outWord | output | DATA_W | Instruction word handed to downstream |
| outStamp | output | STAMP_W | Cycle count of the handoff |

## Verification
Two events can land in the same cycle: completion of the storage read and assertion of nextReady by downstream. The bench provokes this by raising nextReady in the exact cycle it drives memValid. It then requires that outValid stays low in the following cycle, while statusOk is already 1, and that the handoff appears one cycle later with the correct word and a stamp one cycle later than an immediate transfer would carry. The vectors also cover the other order: an OK stage held off by a blocked downstream for several cycles, with a stray memValid injected in between.

// File: rtl/fetchPkg.sv
package fetchPkg;

  // Strobes passed from the control flags to the datapath registers.
  typedef struct packed {
    logic issueRd;      // request a word at the current program counter
    logic captureWord;  // storage data arrives for the outstanding read
    logic handOff;      // held word transfers downstream this cycle
  } fetchStrobes_t;

endpackage

// File: rtl/fetchCtrl.sv
module fetchCtrl
  import fetchPkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          memValid,
  input  logic          nextReady,
  output fetchStrobes_t strb,
  output logic          holding
);

  logic pending;
  logic held;

  always_comb begin
    strb.issueRd     = !pending && !held;
    strb.captureWord = pending && memValid;
    strb.handOff     = held && nextReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
      held    <= 1'b0;
    end else begin
      if (strb.issueRd)
        pending <= 1'b1;
      else if (strb.captureWord)
        pending <= 1'b0;

      if (strb.captureWord)
        held <= 1'b1;
      else if (strb.handOff)
        held <= 1'b0;
    end
  end

  assign holding = held;

endmodule

// File: rtl/fetchPath.sv
module fetchPath
  import fetchPkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int STAMP_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  fetchStrobes_t      strb,
  input  logic [DATA_W-1:0]  memData,
  output logic [ADDR_W-1:0]  pc,
  output logic               outValid,
  output logic [DATA_W-1:0]  outWord,
  output logic [STAMP_W-1:0] outStamp
);

  localparam logic [ADDR_W-1:0]  PC_STEP   = ADDR_W'(1);
  localparam logic [STAMP_W-1:0] CYC_STEP  = STAMP_W'(1);

  logic [DATA_W-1:0]  heldWord;
  logic [STAMP_W-1:0] cycleCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cycleCnt <= '0;
    else       cycleCnt <= cycleCnt + CYC_STEP;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc       <= '0;
      heldWord <= '0;
    end else begin
      if (strb.captureWord) heldWord <= memData;
      if (strb.handOff)     pc       <= pc + PC_STEP;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outWord  <= '0;
      outStamp <= '0;
    end else begin
      outValid <= strb.handOff;
      if (strb.handOff) begin
        outWord  <= heldWord;
        outStamp <= cycleCnt;
      end
    end
  end

endmodule

// File: rtl/instrFetch.sv
module instrFetch
  import fetchPkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int STAMP_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  output logic               memReq,
  output logic [ADDR_W-1:0]  memAddr,
  input  logic               memValid,
  input  logic [DATA_W-1:0]  memData,
  input  logic               nextReady,
  output logic               statusOk,
  output logic               outValid,
  output logic [DATA_W-1:0]  outWord,
  output logic [STAMP_W-1:0] outStamp
);

  fetchStrobes_t strb;
  logic          holding;

  fetchCtrl ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .memValid  (memValid),
    .nextReady (nextReady),
    .strb      (strb),
    .holding   (holding)
  );

  fetchPath #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .STAMP_W (STAMP_W)
  ) path (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .memData  (memData),
    .pc       (memAddr),
    .outValid (outValid),
    .outWord  (outWord),
    .outStamp (outStamp)
  );

  assign memReq   = strb.issueRd;
  assign statusOk = holding;

endmodule

// File: rtl/instrFetchChk.sv
module instrFetchChk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memValid,
  input logic              nextReady,
  input logic              statusOk,
  input logic              outValid
);

  assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

  assert_stall_after_req_R3: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !statusOk);

  assert_capture_ok_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!statusOk && !memReq && memValid) |=> statusOk);

  assert_no_req_while_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    statusOk |-> !memReq);

  assert_hold_while_blocked_R5: assert property (@(posedge clk) disable iff (!rstN)
    (statusOk && !nextReady) |=> statusOk);

  assert_handoff_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    (statusOk && nextReady) |=> (outValid && !statusOk));

  assert_handoff_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(statusOk && nextReady));

  assert_pc_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(statusOk && nextReady) |=> $stable(memAddr));

  assert_pc_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (statusOk && nextReady) |=> (memAddr == $past(memAddr) + ADDR_W'(1)));

endmodule

bind instrFetch instrFetchChk #(.ADDR_W(ADDR_W)) chk (
  .clk       (clk),
  .rstN      (rstN),
  .memReq    (memReq),
  .memAddr   (memAddr),
  .memValid  (memValid),
  .nextReady (nextReady),
  .statusOk  (statusOk),
  .outValid  (outValid)
);

// File: tb/instrFetch_test.sv
`timescale 1ns/1ps
module instrFetch_test;

  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 32;
  localparam int STAMP_W = 32;
  localparam int NV      = 7;

  // Vector fields: {latency[3:0], holdCycles[3:0], readyEarly, strayPulse}
  localparam logic [9:0] VECS [NV] = '{
    {4'd0, 4'd0, 1'b0, 1'b0},
    {4'd1, 4'd2, 1'b0, 1'b0},
    {4'd3, 4'd0, 1'b1, 1'b0},
    {4'd2, 4'd3, 1'b0, 1'b1},
    {4'd5, 4'd1, 1'b0, 1'b0},
    {4'd0, 4'd0, 1'b1, 1'b0},
    {4'd4, 4'd2, 1'b0, 1'b1}
  };

  logic               clk = 1'b0;
  logic               rstN;
  logic               memReq;
  logic [ADDR_W-1:0]  memAddr;
  logic               memValid;
  logic [DATA_W-1:0]  memData;
  logic               nextReady;
  logic               statusOk;
  logic               outValid;
  logic [DATA_W-1:0]  outWord;
  logic [STAMP_W-1:0] outStamp;

  int checks = 0;
  int errors = 0;
  int tbCycle;
  logic [ADDR_W-1:0] expAddr;

  always #2 clk = ~clk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tbCycle <= 0;
    else       tbCycle <= tbCycle + 1;
  end

  instrFetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAMP_W(STAMP_W)) uut (
    .clk(clk), .rstN(rstN), .memReq(memReq), .memAddr(memAddr),
    .memValid(memValid), .memData(memData), .nextReady(nextReady),
    .statusOk(statusOk), .outValid(outValid), .outWord(outWord),
    .outStamp(outStamp)
  );

  function automatic logic [DATA_W-1:0] wordFor(input logic [ADDR_W-1:0] a);
    return {16'hC0DE, a} ^ 32'h00005A5A;
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runOne(input logic [9:0] v);
    int lat   = int'(v[9:6]);
    int hold  = int'(v[5:2]);
    bit early = v[1];
    bit stray = v[0];
    for (int i = 0; i < 40 && !memReq; i++) @(negedge clk);
    chk(memReq == 1'b1, "R2 request issued", 64'(memReq), 64'd1);
    chk(memAddr == expAddr, "R7 request address", 64'(memAddr), 64'(expAddr));
    chk(statusOk == 1'b0, "R3 stalled at request", 64'(statusOk), 64'd0);
    @(negedge clk);
    chk(memReq == 1'b0, "R2 no reissue", 64'(memReq), 64'd0);
    chk(outValid == 1'b0, "R6 single pulse", 64'(outValid), 64'd0);
    for (int i = 0; i < lat; i++) begin
      chk(statusOk == 1'b0, "R3 stalled while outstanding", 64'(statusOk), 64'd0);
      @(negedge clk);
      chk(memReq == 1'b0, "R2 quiet while outstanding", 64'(memReq), 64'd0);
    end
    memValid = 1'b1;
    memData  = wordFor(expAddr);
    if (early) nextReady = 1'b1;
    @(negedge clk);
    memValid = 1'b0;
    memData  = '0;
    chk(statusOk == 1'b1, "R4 ok after capture", 64'(statusOk), 64'd1);
    chk(outValid == 1'b0, "R10 no handoff in capture cycle", 64'(outValid), 64'd0);
    chk(memAddr == expAddr, "R7 pc held at capture", 64'(memAddr), 64'(expAddr));
    if (!early) begin
      for (int i = 0; i < hold; i++) begin
        if (stray) begin
          memValid = 1'b1;
          memData  = ~wordFor(expAddr);
        end
        @(negedge clk);
        memValid = 1'b0;
        memData  = '0;
        chk(statusOk == 1'b1, "R5 ok while blocked", 64'(statusOk), 64'd1);
        chk(memReq == 1'b0, "R5 no read while held", 64'(memReq), 64'd0);
        chk(outValid == 1'b0, "R6 no handoff while blocked", 64'(outValid), 64'd0);
      end
      nextReady = 1'b1;
    end
    @(negedge clk);
    nextReady = 1'b0;
    chk(outValid == 1'b1, "R6 handoff pulse", 64'(outValid), 64'd1);
    chk(outWord == wordFor(expAddr), stray ? "R9 stray ignored, word" : "R6 word",
        64'(outWord), 64'(wordFor(expAddr)));
    chk(outStamp == STAMP_W'(tbCycle - 1), "R8 stamp",
        64'(outStamp), 64'(tbCycle - 1));
    chk(statusOk == 1'b0, "R6 stalled after handoff", 64'(statusOk), 64'd0);
    chk(memAddr == expAddr + ADDR_W'(1), "R7 pc step on handoff",
        64'(memAddr), 64'(expAddr + ADDR_W'(1)));
    expAddr = expAddr + ADDR_W'(1);
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; memValid = 1'b0; memData = '0; nextReady = 1'b0;
    expAddr = '0;
    repeat (3) @(negedge clk);
    chk(statusOk == 1'b0, "R1 reset status", 64'(statusOk), 64'd0);
    chk(outValid == 1'b0, "R1 reset outValid", 64'(outValid), 64'd0);
    chk(memAddr == '0, "R1 reset address", 64'(memAddr), 64'd0);
    rstN = 1'b1;
    chk(memReq == 1'b1, "R1 first request", 64'(memReq), 64'd1);

    for (int k = 0; k < NV; k++) runOne(VECS[k]);

    // Reset while a word is held and downstream is blocked.
    for (int i = 0; i < 40 && !memReq; i++) @(negedge clk);
    @(negedge clk);
    memValid = 1'b1; memData = wordFor(expAddr);
    @(negedge clk);
    memValid = 1'b0;
    chk(statusOk == 1'b1, "R4 held before reset", 64'(statusOk), 64'd1);
    rstN = 1'b0;
    @(negedge clk);
    chk(statusOk == 1'b0, "R1 reset clears held", 64'(statusOk), 64'd0);
    chk(memAddr == '0, "R1 reset clears pc", 64'(memAddr), 64'd0);
    rstN = 1'b1;
    expAddr = '0;
    runOne({4'd1, 4'd1, 1'b0, 1'b0});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule